// File: doc/BRIEF.md
# Coprocessor Coarse Trap Checker

This block decides, for one 32-bit coprocessor register access at a time, whether the hypervisor's coarse-grained controls disable that access. Each request carries the primary and secondary register numbers, a flag that separates a single-register transfer from a register-pair transfer, the current privilege level, and the state of the hypervisor controls: level enabled, host mode, a 16-bit per-register trap mask and an enable that traps implementation-defined registers.

Two independent conditions can raise a trap. The first is a mask lookup. It indexes the mask by the primary number for single transfers and by the secondary number for pair transfers, and it always exempts indices 4 and 14. The second is a fixed table of implementation-defined register encodings that applies to single transfers only. The verdict is registered and appears one clock after the request strobe, together with a result strobe.

Top module: `cp_coarse_trap`

## Requirements
- R1: `res_vld` is high in exactly the cycle after a cycle with `req_vld` high, and is low at all other times.
- R2: A synchronous active-high `rst` clears `res_vld` and `res_trap` at the next clock edge.
- R3: `res_trap` is low whenever `res_vld` is low.
- R4: No trap results unless `hyp_en` is 1 and `cur_el` is 0 or 1. `cur_el` is 2 bits, with values 2 and 3 meaning levels above the guest.
- R5: The mask index is `crn` when `pair_xfer` is 0 and `crm` when `pair_xfer` is 1. A mask trap occurs when `trap_mask[index]` is 1 and `host_mode` is 0.
- R6: An index of 4 or 14 never produces a mask trap, whatever the mask holds.
- R7: With `impdef_trap_en` set and `pair_xfer` 0, the access traps for crn 9 with crm in {0,1,2,5,6,7,8}, crn 10 with crm in {0,1,4,8}, and crn 11 with crm in {0..8,15}. No other combination traps through this check.
- R8: The implementation-defined check ignores `host_mode`. It never fires for pair transfers.
- R9: `res_trap` is the OR of the mask trap and the implementation-defined trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request strobe |
| crn | input | 4 | Primary register number |
| crm | input | 4 | Secondary register number |
| pair_xfer | input | 1 | 1 = register-pair transfer |
| cur_el | input | 2 | Current exception level |
| hyp_en | input | 1 | Hypervisor level enabled |
| host_mode | input | 1 | Host mode active |
| trap_mask | input | 16 | Per-register coarse trap mask |
| impdef_trap_en | input | 1 | Enable for the implementation-defined register trap |
| res_vld | output | 1 | Result strobe, one cycle after request |
| res_trap | output | 1 | Access is trapped |

## Verification
The mask trap and the implementation-defined trap can both fire on the same single-register request. An example is crn 9 with crm 0, when `trap_mask[9]` and the enable are both set. The bench runs a directed pass that sets both conditions at once. It then runs a sweep that turns each contributor off in turn, with host mode or a mask bit cleared, so that the other must still carry the trap alone. A behavioural model computes each verdict from the register tables. The bench compares that verdict to the output on every clock.

// File: rtl/cp_coarse_trap.sv
module cp_coarse_trap #(
  parameter int RW = 4,
  parameter int MW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_vld,
  input  logic [RW-1:0] crn,
  input  logic [RW-1:0] crm,
  input  logic          pair_xfer,
  input  logic [1:0]    cur_el,
  input  logic          hyp_en,
  input  logic          host_mode,
  input  logic [MW-1:0] trap_mask,
  input  logic          impdef_trap_en,
  output logic          res_vld,
  output logic          res_trap
);
  logic [RW-1:0] idx;
  logic          guest, exempt, mask_hit, imp_hit;
  logic [15:0]   set9, set10, set11;

  assign set9  = 16'b0000_0001_1110_0111;
  assign set10 = 16'b0000_0001_0001_0011;
  assign set11 = 16'b1000_0001_1111_1111;

  assign guest    = hyp_en && (cur_el <= 2'd1);
  assign idx      = pair_xfer ? crm : crn;
  assign exempt   = (idx == RW'(4)) || (idx == RW'(14));
  assign mask_hit = !host_mode && !exempt && trap_mask[idx];

  always_comb begin
    imp_hit = 1'b0;
    if (impdef_trap_en && !pair_xfer)
      case (crn)
        RW'(9):  imp_hit = set9[crm];
        RW'(10): imp_hit = set10[crm];
        RW'(11): imp_hit = set11[crm];
        default: imp_hit = 1'b0;
      endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld  <= 1'b0;
      res_trap <= 1'b0;
    end else begin
      res_vld  <= req_vld;
      res_trap <= req_vld && guest && (mask_hit || imp_hit);
    end
  end
endmodule

module cp_coarse_trap_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_vld,
  input logic [3:0]  crn,
  input logic [3:0]  crm,
  input logic        pair_xfer,
  input logic [1:0]  cur_el,
  input logic        hyp_en,
  input logic        host_mode,
  input logic        res_vld,
  input logic        res_trap
);
  a_r1_vld_follows: assert property (@(posedge clk) disable iff (rst) req_vld |=> res_vld);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst) !req_vld |=> !res_vld);
  a_r3_trap_gated:  assert property (@(posedge clk) disable iff (rst) !res_vld |-> !res_trap);
  a_r4_outside_guest: assert property (@(posedge clk) disable iff (rst)
    (req_vld && (!hyp_en || cur_el > 2'd1)) |=> !res_trap);
  a_r8_pair_host: assert property (@(posedge clk) disable iff (rst)
    (req_vld && pair_xfer && host_mode) |=> !res_trap);
  a_r6_exempt_pair: assert property (@(posedge clk) disable iff (rst)
    (req_vld && pair_xfer && (crm == 4'd4 || crm == 4'd14)) |=> !res_trap);
endmodule

bind cp_coarse_trap cp_coarse_trap_chk u_chk (
  .clk(clk), .rst(rst), .req_vld(req_vld), .crn(crn), .crm(crm),
  .pair_xfer(pair_xfer), .cur_el(cur_el), .hyp_en(hyp_en),
  .host_mode(host_mode), .res_vld(res_vld), .res_trap(res_trap)
);

// File: tb/cp_coarse_trap_tb.sv
module cp_coarse_trap_tb;
  logic clk = 0, rst = 1;
  logic req_vld = 0, pair_xfer = 0, hyp_en = 0, host_mode = 0, impdef_trap_en = 0;
  logic [3:0] crn = 0, crm = 0;
  logic [1:0] cur_el = 0;
  logic [15:0] trap_mask = 0;
  logic res_vld, res_trap;
  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit exp_vld = 0, exp_trap = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cp_coarse_trap u_dut (.*);

  function automatic bit model(int n, int m, bit pr, int el, bit he, bit hm,
                               logic [15:0] mk, bit ie);
    int k;
    bit a, b;
    if (!he || el > 1) return 0;
    k = pr ? m : n;
    a = !hm && k != 4 && k != 14 && mk[k];
    b = 0;
    if (ie && !pr) begin
      if (n == 9)  b = m inside {0,1,2,5,6,7,8};
      if (n == 10) b = m inside {0,1,4,8};
      if (n == 11) b = m inside {[0:8],15};
    end
    return a || b;
  endfunction

  always @(posedge clk) begin
    if (rst) begin exp_vld <= 0; exp_trap <= 0; end
    else begin
      exp_vld  <= req_vld;
      exp_trap <= req_vld && model(crn, crm, pair_xfer, cur_el, hyp_en,
                                   host_mode, trap_mask, impdef_trap_en);
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 2) begin
      n_cmp++;
      if (res_vld !== exp_vld || res_trap !== exp_trap) begin
        n_bad++;
        $display("FAIL R1/R3/R4-R9 cyc %0d: vld=%b trap=%b expected vld=%b trap=%b",
                 cyc, res_vld, res_trap, exp_vld, exp_trap);
      end
    end
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog");
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic drive(int n, int m, bit pr, int el, bit he, bit hm,
                       logic [15:0] mk, bit ie, bit v = 1);
    @(posedge clk); #1;
    crn = 4'(n); crm = 4'(m); pair_xfer = pr; cur_el = 2'(el);
    hyp_en = he; host_mode = hm; trap_mask = mk; impdef_trap_en = ie; req_vld = v;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R2: reset state
    if (res_vld !== 0 || res_trap !== 0) begin
      n_bad++; $display("FAIL R2 reset: vld=%b trap=%b expected 0 0", res_vld, res_trap);
    end
    n_cmp++;
    rst = 0;
    // R9: both traps together, then each alone
    drive(9, 0, 0, 1, 1, 0, 16'h0200, 1);
    drive(9, 0, 0, 1, 1, 1, 16'h0200, 1);
    drive(9, 0, 0, 1, 1, 0, 16'h0200, 0);
    drive(9, 3, 0, 0, 1, 0, 16'h0000, 1);
    // R4: level and hypervisor gating
    drive(9, 0, 0, 2, 1, 0, 16'hFFFF, 1);
    drive(9, 0, 0, 3, 1, 0, 16'hFFFF, 1);
    drive(9, 0, 0, 0, 0, 0, 16'hFFFF, 1);
    // R5/R6: pair transfer index and exemptions
    drive(0, 4, 1, 1, 1, 0, 16'hFFFF, 0);
    drive(0, 14, 1, 1, 1, 0, 16'hFFFF, 0);
    drive(4, 3, 0, 1, 1, 0, 16'hFFFF, 0);
    drive(14, 3, 1, 1, 1, 0, 16'h0008, 0);
    drive(3, 14, 1, 1, 1, 0, 16'h0008, 0);
    // R8: pair never impdef; host mode ignored by impdef
    drive(11, 15, 1, 1, 1, 1, 16'h0000, 1);
    drive(11, 15, 0, 1, 1, 1, 16'h0000, 1);
    // R1: gap without valid
    drive(9, 0, 0, 1, 1, 0, 16'hFFFF, 1, 0);
    drive(9, 0, 0, 1, 1, 0, 16'hFFFF, 1, 0);
    // R7: full sweep of impdef table and mask
    for (int n = 0; n < 16; n++)
      for (int m = 0; m < 16; m++)
        for (int p = 0; p < 2; p++)
          drive(n, m, p[0], (n + m) % 4, 1, m[0] & n[0], 16'(1 << ((n * 5 + m) % 16)), 1);
    // R2: reset in the middle of traffic
    drive(9, 0, 0, 1, 1, 0, 16'hFFFF, 1);
    @(posedge clk); #1; rst = 1; req_vld = 1;
    @(posedge clk); #1; rst = 0; req_vld = 0;
    repeat (3) @(posedge clk);
    #1;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule